// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This block owns a 16-bit stack pointer and turns a push or pop of a 16-bit register pair into two single-byte transfers on a byte-wide memory port. The stack grows towards lower addresses: a push moves the pointer down before each byte it stores, and a pop reads at the pointer and then moves it up. Each command always moves exactly two bytes. There is no single-byte form.

A push stores the high byte first and the low byte second, so the low byte ends up at the lower address. A pop reads the low byte first and the high byte second. The pair that comes back is therefore the one most recently pushed. While an operation is running, the unit reports busy and ignores new commands. Software or a sequencer can place the pointer anywhere with a load command, but only while the unit is idle. The memory read data is taken combinationally in the cycle that the read strobe is high.

Top module: `stkptr_unit`

## Requirements
- R1: After reset, the pointer reads 16'h0000 and busy, done, the write strobe and the read strobe are all low.
- R2: A push accepted while idle takes two cycles. In the first cycle the unit writes the high byte at pointer-1. In the second cycle it writes the low byte at pointer-2 and raises done. The pointer ends two lower than it started.
- R3: A pop accepted while idle takes two cycles. In the first cycle the unit reads at the pointer. In the second cycle it reads at pointer+1 and raises done. The pointer ends two higher than it started. From the cycle after done, the popped-pair output holds {byte read second, byte read first}.
- R4: Pops return pairs in last-in first-out order with respect to pushes.
- R5: Pointer arithmetic wraps modulo 65536 in both directions. A push from 16'h0000 writes at 16'hFFFF and then at 16'hFFFE.
- R6: Busy is high during exactly the two transfer cycles. A push, pop or load command sampled while busy has no effect.
- R7: A load sampled while idle sets the pointer to the load value on the next cycle and starts no memory transfer.
- R8: When a load and a push or pop are sampled together while idle, the load is taken and the push or pop is dropped.
- R9: When a push and a pop are sampled together while idle, the push is taken.
- R10: The write and read strobes are never high together, and neither strobe nor done is high while idle.
- R11: The bytes that a push writes are the pair inputs present in the cycle the push was accepted, even if those inputs change afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push command, sampled at the clock edge |
| pop_req | input | 1 | Pop command, sampled at the clock edge |
| pair_hi | input | 8 | High byte of the pair to push |
| pair_lo | input | 8 | Low byte of the pair to push |
| sp_load | input | 1 | Load the pointer from sp_load_val |
| sp_load_val | input | 16 | New pointer value |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid in the read cycle |
| pop_pair | output | 16 | Most recently popped pair |
| sp_now | output | 16 | Current stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last transfer cycle of an operation |

## Verification
Two of this block's functions can fall in the same cycle:
- A pointer load together with a push or pop command.
- A new command arriving in the middle of a running transfer.

Each collision is provoked by raising both command inputs at the same negative edge. The bench does this both while the unit is idle and during the first transfer cycle, when a pop request and a load request are injected together. The outcome is judged at the ports:
- The pointer value on the following cycles.
- The busy flag.
- The absence of any extra memory strobe.
- The bytes later popped back, compared against a reference stack and pointer that the bench maintains itself.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

    localparam int SP_W   = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PUSH_HI,
        PH_PUSH_LO,
        PH_POP_LO,
        PH_POP_HI
    } phase_e;

    typedef enum logic [1:0] {
        SP_HOLD,
        SP_DEC,
        SP_INC,
        SP_LOAD
    } sp_op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } pair_t;

    // One step of the pointer; wraps naturally at the width.
    function automatic logic [SP_W-1:0] sp_step(input logic [SP_W-1:0] v,
                                                input logic up);
        return up ? v + SP_W'(1) : v - SP_W'(1);
    endfunction

    function automatic logic is_push(input phase_e p);
        return (p == PH_PUSH_HI) || (p == PH_PUSH_LO);
    endfunction

    function automatic logic is_pop(input phase_e p);
        return (p == PH_POP_LO) || (p == PH_POP_HI);
    endfunction

endpackage

// File: rtl/stkptr_seq.sv
module stkptr_seq
    import stkptr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   push_req,
    input  logic   pop_req,
    input  logic   sp_load,
    output phase_e phase,
    output sp_op_e sp_op,
    output logic   take_pair,
    output logic   busy,
    output logic   done
);

    phase_e phase_nx;

    always_comb begin
        phase_nx  = phase;
        sp_op     = SP_HOLD;
        take_pair = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (sp_load) begin
                    sp_op = SP_LOAD;
                end else if (push_req) begin
                    phase_nx  = PH_PUSH_HI;
                    take_pair = 1'b1;
                end else if (pop_req) begin
                    phase_nx = PH_POP_LO;
                end
            end
            PH_PUSH_HI: begin
                sp_op    = SP_DEC;
                phase_nx = PH_PUSH_LO;
            end
            PH_PUSH_LO: begin
                sp_op    = SP_DEC;
                phase_nx = PH_IDLE;
            end
            PH_POP_LO: begin
                sp_op    = SP_INC;
                phase_nx = PH_POP_HI;
            end
            PH_POP_HI: begin
                sp_op    = SP_INC;
                phase_nx = PH_IDLE;
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nx;
    end

    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_PUSH_LO) || (phase == PH_POP_HI);

endmodule

// File: rtl/stkptr_reg.sv
module stkptr_reg
    import stkptr_pkg::*;
#(
    parameter int             W      = SP_W,
    parameter logic [W-1:0]   RST_SP = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  sp_op_e       sp_op,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] sp
);

    logic [W-1:0] sp_nx;

    always_comb begin
        unique case (sp_op)
            SP_DEC:  sp_nx = sp - W'(1);
            SP_INC:  sp_nx = sp + W'(1);
            SP_LOAD: sp_nx = ld_val;
            default: sp_nx = sp;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sp <= RST_SP;
        else     sp <= sp_nx;
    end

endmodule

// File: rtl/stkptr_port.sv
module stkptr_port
    import stkptr_pkg::*;
#(
    parameter int AW = SP_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase,
    input  logic          take_pair,
    input  logic [DW-1:0] in_hi,
    input  logic [DW-1:0] in_lo,
    input  logic [AW-1:0] sp,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          we,
    output logic          re,
    output logic [2*DW-1:0] popped
);

    logic [DW-1:0] held_hi, held_lo, first_rd;

    // Pair captured at acceptance so the inputs may move on.
    always_ff @(posedge clk) begin
        if (rst) begin
            held_hi <= '0;
            held_lo <= '0;
        end else if (take_pair) begin
            held_hi <= in_hi;
            held_lo <= in_lo;
        end
    end

    always_comb begin
        we    = is_push(phase);
        re    = is_pop(phase);
        addr  = we ? sp_step(sp, 1'b0) : sp;
        wdata = (phase == PH_PUSH_HI) ? held_hi : held_lo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            first_rd <= '0;
            popped   <= '0;
        end else begin
            if (phase == PH_POP_LO) first_rd <= rdata;
            if (phase == PH_POP_HI) popped   <= {rdata, first_rd};
        end
    end

endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
    import stkptr_pkg::*;
#(
    parameter int            AW     = SP_W,
    parameter int            DW     = BYTE_W,
    parameter logic [AW-1:0] RST_SP = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_req,
    input  logic            pop_req,
    input  logic [DW-1:0]   pair_hi,
    input  logic [DW-1:0]   pair_lo,
    input  logic            sp_load,
    input  logic [AW-1:0]   sp_load_val,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_we,
    output logic            mem_re,
    input  logic [DW-1:0]   mem_rdata,
    output logic [2*DW-1:0] pop_pair,
    output logic [AW-1:0]   sp_now,
    output logic            busy,
    output logic            done
);

    phase_e phase;
    sp_op_e sp_op;
    logic   take_pair;

    stkptr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .sp_load   (sp_load),
        .phase     (phase),
        .sp_op     (sp_op),
        .take_pair (take_pair),
        .busy      (busy),
        .done      (done)
    );

    stkptr_reg #(.W(AW), .RST_SP(RST_SP)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .sp_op  (sp_op),
        .ld_val (sp_load_val),
        .sp     (sp_now)
    );

    stkptr_port #(.AW(AW), .DW(DW)) u_port (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .take_pair (take_pair),
        .in_hi     (pair_hi),
        .in_lo     (pair_lo),
        .sp        (sp_now),
        .rdata     (mem_rdata),
        .addr      (mem_addr),
        .wdata     (mem_wdata),
        .we        (mem_we),
        .re        (mem_re),
        .popped    (pop_pair)
    );

endmodule

// File: rtl/stkptr_chk.sv
module stkptr_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          push_req,
    input logic          pop_req,
    input logic          sp_load,
    input logic [AW-1:0] sp_load_val,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] sp_now,
    input logic          busy,
    input logic          done
);

    // R2
    push_second_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !done) |=> (mem_we && done && mem_addr == $past(mem_addr) - AW'(1)));

    // R3
    pop_second_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_re && !done) |=> (mem_re && done && mem_addr == $past(mem_addr) + AW'(1)));

    // R6
    busy_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (sp_now == $past(sp_now) - AW'(1) || sp_now == $past(sp_now) + AW'(1)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R7
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && sp_load) |=> (sp_now == $past(sp_load_val) && !busy));

    // R9
    push_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && push_req && !sp_load) |=> (mem_we && !mem_re));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !mem_re && !done));

endmodule

bind stkptr_unit stkptr_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .push_req    (push_req),
    .pop_req     (pop_req),
    .sp_load     (sp_load),
    .sp_load_val (sp_load_val),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .sp_now      (sp_now),
    .busy        (busy),
    .done        (done)
);

// File: tb/stkptr_unit_bench.sv
module stkptr_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 24;

    logic        clk = 1'b0;
    logic        rst;
    logic        push_req, pop_req, sp_load;
    logic [7:0]  pair_hi, pair_lo;
    logic [15:0] sp_load_val;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_we, mem_re;
    logic [15:0] pop_pair, sp_now;
    logic        busy, done;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem [0:255];
    logic [15:0] ref_sp;
    logic [15:0] ref_stk [0:DEPTH-1];
    int          ref_top = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stkptr_unit u_stkptr_unit (
        .clk (clk), .rst (rst), .push_req (push_req), .pop_req (pop_req),
        .pair_hi (pair_hi), .pair_lo (pair_lo), .sp_load (sp_load),
        .sp_load_val (sp_load_val), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_we (mem_we), .mem_re (mem_re), .mem_rdata (mem_rdata),
        .pop_pair (pop_pair), .sp_now (sp_now), .busy (busy), .done (done)
    );

    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[7:0]];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_push(input logic [7:0] hi, input logic [7:0] lo,
                           input logic probe, input logic with_pop);
        @(negedge clk);
        push_req = 1'b1; pop_req = with_pop; pair_hi = hi; pair_lo = lo;
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0;
        pair_hi = ~hi; pair_lo = ~lo;   // R11: inputs move after acceptance
        if (probe) begin                 // R6: commands while busy
            pop_req = 1'b1; push_req = 1'b1; sp_load = 1'b1; sp_load_val = 16'h5A5A;
        end
        chk(mem_we && !mem_re && busy && !done, "R2 first cycle strobes",
            {mem_we, mem_re, busy, done}, 4'b1010);
        chk(mem_addr == ref_sp - 16'd1, "R2/R5 high byte addr", mem_addr, ref_sp - 16'd1);
        chk(mem_wdata == hi, "R11 high byte data", mem_wdata, hi);
        @(negedge clk);
        pop_req = 1'b0; push_req = 1'b0; sp_load = 1'b0;
        chk(mem_we && done && busy, "R2 second cycle done", {mem_we, done, busy}, 3'b111);
        chk(mem_addr == ref_sp - 16'd2, "R2/R5 low byte addr", mem_addr, ref_sp - 16'd2);
        chk(mem_wdata == lo, "R11 low byte data", mem_wdata, lo);
        @(negedge clk);
        ref_sp = ref_sp - 16'd2;
        ref_stk[ref_top] = {hi, lo};
        ref_top++;
        chk(sp_now == ref_sp, "R2/R6 pointer after push", sp_now, ref_sp);
        chk(!busy && !mem_we && !mem_re, "R6 idle after push", {busy, mem_we, mem_re}, 0);
    endtask

    task automatic do_pop();
        logic [15:0] exp;
        ref_top--;
        exp = ref_stk[ref_top];
        @(negedge clk);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        chk(mem_re && !mem_we && busy && !done, "R3 first read",
            {mem_re, mem_we, busy, done}, 4'b1010);
        chk(mem_addr == ref_sp, "R3 low byte addr", mem_addr, ref_sp);
        @(negedge clk);
        chk(mem_re && done, "R3 second read done", {mem_re, done}, 2'b11);
        chk(mem_addr == ref_sp + 16'd1, "R3/R5 high byte addr", mem_addr, ref_sp + 16'd1);
        @(negedge clk);
        ref_sp = ref_sp + 16'd2;
        chk(pop_pair == exp, "R4 LIFO pair", pop_pair, exp);
        chk(sp_now == ref_sp, "R3 pointer after pop", sp_now, ref_sp);
        chk(!busy && !done, "R10 idle after pop", {busy, done}, 0);
    endtask

    task automatic do_load(input logic [15:0] v, input logic with_push, input logic with_pop);
        @(negedge clk);
        sp_load = 1'b1; sp_load_val = v; push_req = with_push; pop_req = with_pop;
        @(negedge clk);
        sp_load = 1'b0; push_req = 1'b0; pop_req = 1'b0;
        ref_sp = v;
        chk(sp_now == v, "R7 pointer loaded", sp_now, v);
        chk(!busy && !mem_we && !mem_re, "R8/R7 no transfer on load",
            {busy, mem_we, mem_re}, 0);
        @(negedge clk);
        chk(!busy && sp_now == v, "R8 command dropped", {busy, sp_now}, {1'b0, v});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; push_req = 0; pop_req = 0; sp_load = 0;
        pair_hi = 0; pair_lo = 0; sp_load_val = 0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ref_sp = 16'h0000;
        chk(sp_now == 16'h0000, "R1 reset pointer", sp_now, 0);
        chk(!busy && !done && !mem_we && !mem_re, "R1 reset outputs",
            {busy, done, mem_we, mem_re}, 0);

        // R5: push from 0000 wraps to FFFF/FFFE, pop wraps back
        do_push(8'hC3, 8'h3C, 1'b0, 1'b0);
        do_pop();
        chk(ref_sp == 16'h0000 && sp_now == 16'h0000, "R5 wrap return", sp_now, 0);

        // R4: sweep of nested pushes then pops at several bases
        for (int b = 0; b < 3; b++) begin
            do_load(b == 0 ? 16'h1234 : (b == 1 ? 16'h0001 : 16'hFFF0), 1'b0, 1'b0);
            for (int i = 0; i < 8; i++)
                do_push(8'(i * 37 + b * 11 + 5), 8'(i ^ 8'hA5 ^ (b << 4)), 1'b0, 1'b0);
            for (int i = 0; i < 8; i++) do_pop();
        end

        // Interleaved push/pop patterns
        do_load(16'h0100, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            do_push(8'(i * 3 + 1), 8'(255 - i), 1'b0, 1'b0);
            do_push(8'(i + 100), 8'(i * 7), 1'b0, 1'b0);
            do_pop();
        end
        for (int i = 0; i < 6; i++) do_pop();

        // R6: commands injected while busy are ignored
        do_load(16'h0080, 1'b0, 1'b0);
        do_push(8'h11, 8'h22, 1'b1, 1'b0);
        do_push(8'h33, 8'h44, 1'b1, 1'b0);
        do_pop();
        do_pop();

        // R9: push and pop together, push wins
        do_push(8'h9E, 8'hE9, 1'b0, 1'b1);
        do_pop();

        // R8: load together with push, and with pop
        do_load(16'h4000, 1'b1, 1'b0);
        do_load(16'h4444, 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule